// File: doc/BRIEF.md
# 32-bit Arithmetic Unit with Zero Flag

This block is the arithmetic unit of a small 32-bit load/store processor. It takes two operands and a 4-bit function code from the control unit and returns a 32-bit result in the same cycle. The operations are add, subtract, multiply, increment, decrement, single-bit shifts that fill with zero, and pass-through of either operand. Pass-through lets loads, load-immediate and register exchange send data through the unit.

A single zero flag is kept for the conditional branches. The flag is written on a rising clock edge only when the control unit asserts the flag-enable line and the function code is a defined one. The reset input is asynchronous and active-low. The block releases it internally through a two-stage synchronizer, so the flag leaves reset on a clock edge.

Top module: `alu_zflag`

## Requirements
- R1: Code 0 returns op_a unchanged on result, and code 1 returns op_b unchanged.
- R2: Code 2 returns op_a + op_b, truncated to 32 bits.
- R3: Code 3 returns op_a - op_b, truncated to 32 bits (modulo 2^32).
- R4: Code 4 returns the low 32 bits of the product op_a * op_b.
- R5: Code 5 returns op_a + 1 and code 6 returns op_a - 1, both wrapping modulo 2^32.
- R6: Code 7 returns op_a[30:0] with a 0 appended as bit 0.
- R7: Code 8 returns a 0 in bit 31 followed by op_a[31:1].
- R8: Codes 9 to 15 give a result of zero, and zero_flag keeps its value across the edge even when flag_en is high.
- R9: On a rising edge with flag_en high and a code from 0 to 8, zero_flag becomes 1 if the 32-bit result is zero and 0 otherwise.
- R10: On a rising edge with flag_en low, zero_flag keeps its value.
- R11: Driving rst_n low clears zero_flag at once, without waiting for a clock edge. After rst_n rises, flag updates take effect from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| func_sel | input | 4 | Function code, 0 to 8 defined |
| flag_en | input | 1 | Enables the zero flag update on this edge |
| result | output | 32 | Combinational result |
| zero_flag | output | 1 | Registered zero flag |

## Verification
A wrong decode of the function code, or a wrong operation inside the shared adder, appears on result in the same cycle the code is applied. Because of that, every function is compared against arithmetic over corner and pseudo-random operands before the next edge. The flag is the only state in the block. A stale, wrongly set or wrongly held flag appears on zero_flag one edge after the offending cycle, so the flag is compared after every edge, including edges with the enable low and edges with an undefined code. Reset is checked both for the immediate clear and for the delayed resumption of updates.

// File: rtl/alu_zflag_pkg.sv
package alu_zflag_pkg;
  localparam int FN_W    = 4;
  localparam int FN_LAST = 8;

  typedef enum logic [FN_W-1:0] {
    FN_PASS_A = 4'd0,
    FN_PASS_B = 4'd1,
    FN_ADD    = 4'd2,
    FN_SUB    = 4'd3,
    FN_MUL    = 4'd4,
    FN_INC    = 4'd5,
    FN_DEC    = 4'd6,
    FN_SHL    = 4'd7,
    FN_SHR    = 4'd8
  } fn_e;

  typedef enum logic [1:0] {
    AS_ADD = 2'd0,
    AS_SUB = 2'd1,
    AS_INC = 2'd2,
    AS_DEC = 2'd3
  } as_mode_e;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_zflag_pkg::*;
#(
  parameter int W = 32
) (
  input  as_mode_e       mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum
);
  logic [W-1:0] b_eff;
  logic         cin;

  always_comb begin
    unique case (mode)
      AS_ADD: begin b_eff = b;          cin = 1'b0; end
      AS_SUB: begin b_eff = ~b;         cin = 1'b1; end
      AS_INC: begin b_eff = '0;         cin = 1'b1; end
      default: begin b_eff = '1;        cin = 1'b0; end
    endcase
  end

  assign sum = a + b_eff + W'(cin);
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo
);
  assign prod_lo = a * b;
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] shl,
  output logic [W-1:0] shr
);
  assign shl = {a[W-2:0], 1'b0};
  assign shr = {1'b0, a[W-1:1]};
endmodule

// File: rtl/alu_zflag_reg.sv
module alu_zflag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] res,
  output logic         z
);
  logic z_q;
  logic z_d;

  always_comb begin
    z_d = z_q;
    if (load_en) z_d = (res == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) z_q <= 1'b0;
    else        z_q <= z_d;
  end

  assign z = z_q;

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(z));

  a_r9_load_tracks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (z == $past(res == '0)));
endmodule

// File: rtl/alu_zflag.sv
module alu_zflag
  import alu_zflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FN_W-1:0]   func_sel,
  input  logic              flag_en,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag
);
  localparam logic [FN_W-1:0] LAST_CODE = FN_W'(FN_LAST);

  logic              rst_int_n;
  logic              code_ok;
  as_mode_e          as_mode;
  logic [DATA_W-1:0] as_sum;
  logic [DATA_W-1:0] mul_lo;
  logic [DATA_W-1:0] sh_l;
  logic [DATA_W-1:0] sh_r;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    code_ok = (func_sel <= LAST_CODE);
    unique case (func_sel)
      FN_SUB:  as_mode = AS_SUB;
      FN_INC:  as_mode = AS_INC;
      FN_DEC:  as_mode = AS_DEC;
      default: as_mode = AS_ADD;
    endcase
  end

  alu_addsub #(.W(DATA_W)) u_addsub (
    .mode(as_mode), .a(op_a), .b(op_b), .sum(as_sum)
  );

  alu_mul #(.W(DATA_W)) u_mul (
    .a(op_a), .b(op_b), .prod_lo(mul_lo)
  );

  alu_shift1 #(.W(DATA_W)) u_shift (
    .a(op_a), .shl(sh_l), .shr(sh_r)
  );

  always_comb begin
    unique case (func_sel)
      FN_PASS_A: result = op_a;
      FN_PASS_B: result = op_b;
      FN_ADD, FN_SUB, FN_INC, FN_DEC: result = as_sum;
      FN_MUL:    result = mul_lo;
      FN_SHL:    result = sh_l;
      FN_SHR:    result = sh_r;
      default:   result = '0;
    endcase
  end

  alu_zflag_reg #(.W(DATA_W)) u_zflag (
    .clk(clk), .rst_n(rst_int_n), .load_en(flag_en & code_ok),
    .res(result), .z(zero_flag)
  );

  a_r8_unused_gives_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel > LAST_CODE) |-> (result == '0));

  a_r8_unused_keeps_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel > LAST_CODE) |=> $stable(zero_flag));

  a_r1_pass_a: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel == FN_PASS_A) |-> (result == op_a));

  a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel == FN_INC) |-> ((result - op_a) == DATA_W'(1)));

  a_r6_shl_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel == FN_SHL) |-> (result[0] == 1'b0 && result[DATA_W-1:1] == op_a[DATA_W-2:0]));

  a_r7_shr_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (func_sel == FN_SHR) |-> (result[DATA_W-1] == 1'b0 && result[DATA_W-2:0] == op_a[DATA_W-1:1]));
endmodule

// File: tb/tb_alu_zflag.sv
`timescale 1ns/1ps
module tb_alu_zflag;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [3:0]  func_sel;
  logic        flag_en;
  logic [31:0] result;
  logic        zero_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic z_exp;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  alu_zflag dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .func_sel(func_sel), .flag_en(flag_en),
    .result(result), .zero_flag(zero_flag)
  );

  function automatic logic [31:0] model(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    case (c)
      4'd0: r = a;
      4'd1: r = b;
      4'd2: r = a + b;
      4'd3: r = a - b;
      4'd4: r = a * b;
      4'd5: r = a + 32'd1;
      4'd6: r = a - 32'd1;
      4'd7: r = a << 1;
      4'd8: r = a >> 1;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c)
      4'd0, 4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] corner(int k);
    case (k % 6)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return 32'h0001_0000;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; func_sel = 4'd0; flag_en = 1'b0;
    z_exp = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset state", {31'd0, zero_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 48; i++) begin
      logic [31:0] a, b;
      step_rand();
      a = (i < 6) ? corner(i) : lfsr;
      step_rand();
      if (i % 5 == 0)      b = a;
      else if (i < 6)      b = corner(i + 3);
      else if (i % 7 == 0) b = corner(i);
      else                 b = lfsr;
      for (int c = 0; c < 16; c++) begin
        logic [31:0] e;
        logic fe;
        @(negedge clk);
        check("R9/R10/R8 flag", {31'd0, zero_flag}, {31'd0, z_exp});
        fe = ((i + c) % 3) != 0;
        op_a = a; op_b = b; func_sel = 4'(c); flag_en = fe;
        #1;
        e = model(4'(c), a, b);
        check(tag(4'(c)), result, e);
        if (fe && c <= 8) z_exp = (e == 32'd0);
      end
    end
    @(negedge clk);
    check("R9/R10/R8 flag", {31'd0, zero_flag}, {31'd0, z_exp});

    // R9: force a zero result and load the flag
    op_a = 32'd0; func_sel = 4'd0; flag_en = 1'b1;
    @(negedge clk);
    check("R9 set on zero", {31'd0, zero_flag}, 32'd1);
    // R8: undefined code with enable high keeps the set flag
    op_a = 32'd5; func_sel = 4'd12; flag_en = 1'b1;
    @(negedge clk);
    check("R8 flag kept", {31'd0, zero_flag}, 32'd1);
    // R10: enable low with a nonzero result keeps the flag
    func_sel = 4'd0; flag_en = 1'b0;
    @(negedge clk);
    check("R10 flag held", {31'd0, zero_flag}, 32'd1);
    // R11: asynchronous clear
    #2 rst_n = 1'b0;
    #1 check("R11 async clear", {31'd0, zero_flag}, 32'd0);
    op_a = 32'd0; func_sel = 4'd0; flag_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first edge after release", {31'd0, zero_flag}, 32'd0);
    @(negedge clk);
    check("R11 second edge after release", {31'd0, zero_flag}, 32'd0);
    @(negedge clk);
    check("R11 updates resume", {31'd0, zero_flag}, 32'd1);
    // R9: nonzero result clears the flag
    op_a = 32'h0000_0100; func_sel = 4'd7;
    @(negedge clk);
    check("R9 clear on nonzero", {31'd0, zero_flag}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule